// File: doc/BRIEF.md
# On-Demand Oscillator Request Controller

This block decides whether a single oscillator source is running. Several peripheral channels can ask for the clock. Each channel's request counts only when three things are enabled: the peripheral's own enable, that channel's clock-channel enable, and the shared generator enable that sits between the channels and the source. The block also holds three control bits for the source: a master enable, an on-demand bit and a keep-running-in-standby bit. It takes a standby-mode input from the power manager.

With on-demand set, the source runs only while at least one gated request is present. It stops as soon as the last such request goes away. With on-demand clear, an enabled source runs all the time. Standby stops the source unless the keep-running-in-standby bit is set. When that bit is set, standby changes nothing.

The oscillator itself is modelled as a plain run enable. A programmable startup counter holds off the ready output until the modelled startup time has passed. Ready drops in the same cycle that the source stops.

Top module: `clk_ondemand_ctrl`

## Requirements
- R1: With `cfg_enable` low, `src_run` and `src_ready` are both low one cycle later, whatever the requests are.
- R2: The request from channel i counts as qualified only when `chan_req[i]`, `periph_en[i]`, `chan_en[i]` and `gen_en` are all 1. A request that lacks any one of these has no effect on `src_run`.
- R3: With `cfg_enable` and `cfg_ondemand` high, and standby not blocking, `src_run` in the next cycle is 1 exactly when at least one qualified request is present in this cycle.
- R4: With `cfg_enable` high and `cfg_ondemand` low, and standby not blocking, `src_run` is 1 in the next cycle with no request present.
- R5: With `standby` high and `cfg_runstdby` low, `src_run` is 0 in the next cycle. With `cfg_runstdby` high, standby has no effect on the behaviour.
- R6: `src_ready` rises exactly `startup_cycles`+1 cycles after `src_run` rises, and stays high while `src_run` stays high. A `startup_cycles` of 0 gives ready one cycle after run.
- R7: `src_ready` falls in the same cycle that `src_run` falls. Every new start counts the full startup time again from zero.
- R8: A new qualified request that arrives, or a change in which channels are requesting, while startup is in progress does not restart the startup count, as long as the source stays running.
- R9: While `rst_n` is low, `src_run` and `src_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Source master enable |
| cfg_ondemand | input | 1 | Run only while a qualified request is present |
| cfg_runstdby | input | 1 | Keep the source policy active in standby |
| standby | input | 1 | Device is in standby mode |
| gen_en | input | 1 | Enable of the generator between the channels and the source |
| chan_en | input | NUM_CH | Per-channel clock-channel enables |
| periph_en | input | NUM_CH | Per-channel peripheral enables |
| chan_req | input | NUM_CH | Per-channel clock requests |
| startup_cycles | input | CNT_W | Startup wait, in cycles, before ready |
| src_run | output | 1 | Source is running |
| src_ready | output | 1 | Source has finished startup and is usable |

## Verification
Two events can fall in the same cycle: the startup counter reaching its limit, and a stop caused by the last request leaving or by standby. They can also meet a start with a change in which channels are requesting. The bench provokes a stop on the exact cycle that ready would have risen, and it swaps the active channel in the middle of startup. A behavioural model that counts the cycles since run rose judges every cycle. It expects ready to stay low on that stop cycle, and it expects the swap to leave the ready time unchanged.

// File: rtl/clk_ondemand_pkg.sv
package clk_ondemand_pkg;

    typedef enum logic [1:0] {
        SRC_OFF      = 2'd0,
        SRC_STARTING = 2'd1,
        SRC_READY    = 2'd2
    } src_state_e;

endpackage

// File: rtl/cod_req_gate.sv
module cod_req_gate #(
    parameter int NUM_CH = 4
) (
    input  logic              gen_en,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] periph_en,
    input  logic [NUM_CH-1:0] chan_req,
    output logic              any_req
);
    logic [NUM_CH-1:0] passed;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign passed[i] = chan_req[i] & periph_en[i] & chan_en[i];
    end

    assign any_req = gen_en & (|passed);
endmodule

// File: rtl/cod_run_policy.sv
module cod_run_policy (
    input  logic cfg_enable,
    input  logic cfg_ondemand,
    input  logic cfg_runstdby,
    input  logic standby,
    input  logic any_req,
    output logic want_run
);
    logic allowed;

    always_comb begin
        allowed  = cfg_enable & (~standby | cfg_runstdby);
        want_run = allowed & (~cfg_ondemand | any_req);
    end
endmodule

// File: rtl/cod_startup_fsm.sv
module cod_startup_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_run,
    input  logic [CNT_W-1:0] startup_cycles,
    output logic             run,
    output logic             ready
);
    import clk_ondemand_pkg::*;

    typedef struct packed {
        src_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!want_run) begin
            fsm_d.st  = SRC_OFF;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                SRC_OFF: begin
                    fsm_d.st  = SRC_STARTING;
                    fsm_d.cnt = '0;
                end
                SRC_STARTING: begin
                    if (fsm_q.cnt >= startup_cycles) begin
                        fsm_d.st = SRC_READY;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                SRC_READY: fsm_d.st = SRC_READY;
                default: begin
                    fsm_d.st  = SRC_OFF;
                    fsm_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= SRC_OFF;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign run   = (fsm_q.st != SRC_OFF);
    assign ready = (fsm_q.st == SRC_READY);
endmodule

// File: rtl/clk_ondemand_ctrl.sv
module clk_ondemand_ctrl #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_ondemand,
    input  logic              cfg_runstdby,
    input  logic              standby,
    input  logic              gen_en,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] periph_en,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [CNT_W-1:0]  startup_cycles,
    output logic              src_run,
    output logic              src_ready
);
    logic any_req;
    logic want_run;

    cod_req_gate #(.NUM_CH(NUM_CH)) u_gate (
        .gen_en    (gen_en),
        .chan_en   (chan_en),
        .periph_en (periph_en),
        .chan_req  (chan_req),
        .any_req   (any_req)
    );

    cod_run_policy u_policy (
        .cfg_enable   (cfg_enable),
        .cfg_ondemand (cfg_ondemand),
        .cfg_runstdby (cfg_runstdby),
        .standby      (standby),
        .any_req      (any_req),
        .want_run     (want_run)
    );

    cod_startup_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .want_run       (want_run),
        .startup_cycles (startup_cycles),
        .run            (src_run),
        .ready          (src_ready)
    );
endmodule

// File: rtl/clk_ondemand_ctrl_chk.sv
module clk_ondemand_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_ondemand,
    input  logic              cfg_runstdby,
    input  logic              standby,
    input  logic              gen_en,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] periph_en,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [CNT_W-1:0]  startup_cycles,
    input  logic              src_run,
    input  logic              src_ready
);
    logic live_req;
    logic stby_ok;
    logic unused_ok;

    assign live_req  = gen_en && ((chan_req & chan_en & periph_en) != '0);
    assign stby_ok   = !standby || cfg_runstdby;
    assign unused_ok = |startup_cycles;

    // R1
    a_r1_disabled_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!src_run && !src_ready));

    // R2
    a_r2_unqualified_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ondemand && !live_req) |=> !src_run);

    // R3
    a_r3_request_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_ondemand && stby_ok && live_req) |=> src_run);

    // R4
    a_r4_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_ondemand && stby_ok) |=> src_run);

    // R5
    a_r5_standby_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !cfg_runstdby) |=> !src_run);

    // R6
    a_r6_ready_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ready) |-> $past(src_run));

    // R7
    a_r7_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !src_run |-> !src_ready);
endmodule

bind clk_ondemand_ctrl clk_ondemand_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_ondemand   (cfg_ondemand),
    .cfg_runstdby   (cfg_runstdby),
    .standby        (standby),
    .gen_en         (gen_en),
    .chan_en        (chan_en),
    .periph_en      (periph_en),
    .chan_req       (chan_req),
    .startup_cycles (startup_cycles),
    .src_run        (src_run),
    .src_ready      (src_ready)
);

// File: tb/clk_ondemand_ctrl_test.sv
`timescale 1ns/1ps
module clk_ondemand_ctrl_test;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_enable = 1'b0;
    logic              cfg_ondemand = 1'b0;
    logic              cfg_runstdby = 1'b0;
    logic              standby = 1'b0;
    logic              gen_en = 1'b0;
    logic [NUM_CH-1:0] chan_en = '0;
    logic [NUM_CH-1:0] periph_en = '0;
    logic [NUM_CH-1:0] chan_req = '0;
    logic [CNT_W-1:0]  startup_cycles = '0;
    logic              src_run;
    logic              src_ready;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    clk_ondemand_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ondemand(cfg_ondemand),
        .cfg_runstdby(cfg_runstdby), .standby(standby), .gen_en(gen_en),
        .chan_en(chan_en), .periph_en(periph_en), .chan_req(chan_req),
        .startup_cycles(startup_cycles), .src_run(src_run), .src_ready(src_ready)
    );

    // behavioural reference: run follows the policy one cycle later,
    // ready once run has been high for startup+2 consecutive samples
    bit m_run = 0;
    int run_len = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run   <= 0;
            run_len <= 0;
        end else begin
            bit q;
            bit w;
            q = 0;
            for (int i = 0; i < NUM_CH; i++)
                if (chan_req[i] && chan_en[i] && periph_en[i] && gen_en) q = 1;
            w = cfg_enable && (!standby || cfg_runstdby) && (!cfg_ondemand || q);
            m_run   <= w;
            run_len <= w ? run_len + 1 : 0;
        end
    end

    function automatic bit m_ready();
        return m_run && (run_len >= int'(startup_cycles) + 2);
    endfunction

    always @(negedge clk) begin
        n_tests++;
        if (src_run !== m_run || src_ready !== m_ready()) begin
            n_fail++;
            $display("FAIL %s model: run=%b ready=%b expected run=%b ready=%b",
                     cur_req, src_run, src_ready, m_run, m_ready());
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic act_run, logic act_rdy, bit e_run, bit e_rdy, string tag);
        n_tests++;
        if (act_run !== e_run || act_rdy !== e_rdy) begin
            n_fail++;
            $display("FAIL %s: run=%b ready=%b expected run=%b ready=%b",
                     tag, act_run, act_rdy, e_run, e_rdy);
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        startup_cycles = 8'd5;
        step(3);
        chk(src_run, src_ready, 0, 0, "R9 reset");
        rst_n = 1'b1;
        step(1);

        // R1: disabled, everything else asks for the clock
        cur_req = "R1";
        gen_en = 1; chan_en = '1; periph_en = '1; chan_req = '1;
        step(3);
        chk(src_run, src_ready, 0, 0, "R1 disabled");

        // R4 + R6: always-on with S=5
        cur_req = "R4";
        chan_req = '0; cfg_enable = 1;
        step(1);
        chk(src_run, src_ready, 1, 0, "R4 runs without request");
        cur_req = "R6";
        step(5);
        chk(src_run, src_ready, 1, 0, "R6 ready not before S+1");
        step(1);
        chk(src_run, src_ready, 1, 1, "R6 ready at S+1");

        // R5/R7: standby blocks, ready drops with run
        cur_req = "R5";
        standby = 1;
        step(1);
        chk(src_run, src_ready, 0, 0, "R5/R7 standby stop drops ready");
        cfg_runstdby = 1;
        step(1);
        chk(src_run, src_ready, 1, 0, "R5 runstdby keeps running");
        cur_req = "R7";
        step(6);
        chk(src_run, src_ready, 1, 1, "R7 full recount after restart");
        standby = 0; cfg_runstdby = 0;

        // R3/R2: on-demand gating
        cur_req = "R3";
        cfg_ondemand = 1;
        step(1);
        chk(src_run, src_ready, 0, 0, "R3 no request stops");
        cur_req = "R2";
        chan_req = 4'b0010; chan_en = 4'b1101;
        step(2);
        chk(src_run, src_ready, 0, 0, "R2 channel disabled");
        chan_en = '1; periph_en = 4'b1101;
        step(2);
        chk(src_run, src_ready, 0, 0, "R2 peripheral disabled");
        periph_en = '1; gen_en = 0;
        step(2);
        chk(src_run, src_ready, 0, 0, "R2 generator disabled");
        gen_en = 1;
        step(1);
        chk(src_run, src_ready, 1, 0, "R3 qualified request starts");

        // R8: swap channels mid-startup
        cur_req = "R8";
        step(2);
        chan_req = 4'b0100;
        step(1);
        chan_req = 4'b1100;
        step(2);
        chk(src_run, src_ready, 1, 0, "R8 still starting");
        step(1);
        chk(src_run, src_ready, 1, 1, "R8 ready on original schedule");

        // R7: stop on the cycle ready would rise
        cur_req = "R7";
        chan_req = '0;
        step(1);
        chk(src_run, src_ready, 0, 0, "R3/R7 last request gone");
        chan_req = 4'b0001;
        step(6);
        chan_req = '0;
        step(1);
        chk(src_run, src_ready, 0, 0, "R7 stop wins over ready");

        // R6: zero startup
        cur_req = "R6";
        startup_cycles = 8'd0;
        chan_req = 4'b1000;
        step(1);
        chk(src_run, src_ready, 1, 0, "R6 zero startup run");
        step(1);
        chk(src_run, src_ready, 1, 1, "R6 zero startup ready");

        // R5: on-demand in standby with runstdby set, then cleared
        cur_req = "R5";
        standby = 1; cfg_runstdby = 1;
        step(2);
        chk(src_run, src_ready, 1, 1, "R5 request honoured in standby");
        cfg_runstdby = 0;
        step(1);
        chk(src_run, src_ready, 0, 0, "R5 request ignored in standby");

        // R1: enable cleared while running
        cur_req = "R1";
        standby = 0;
        step(3);
        cfg_enable = 0;
        step(1);
        chk(src_run, src_ready, 0, 0, "R1 enable cleared");

        step(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule